// File: doc/BRIEF.md
# PCM Bit Clock, Frame Sync and Serial Shift Engine

This block is the master-side timing and data engine of a DSP-format PCM audio port. It counts pulses of one of two source-clock tick inputs and divides them into a bit clock. The bit clock is divided again into frames, and a one-period frame sync pulse marks the start of each frame. Each frame carries two 16-bit channels, left then right. Both channels are shifted out MSB-first on the transmit pin, and two channels are assembled from the receive pin.

A show-ahead transmit FIFO is drained through a one-cycle pop strobe. A receive FIFO is filled through a one-cycle push strobe with the sample beside it. Each direction has its own choice of where the first data bit sits. It can share the sync slot or sit in the slot after it. A policy input decides whether the bit clock keeps running while neither direction is active.

Everything runs on the single system clock `clk`. The source clocks reach the block as tick pulses in that domain.

Top module: `pcm_master_port`

## Requirements
- R1: Once the engine starts running, `pcm_sclk` begins low. Each level lasts `sclk_div`+1 counted source ticks, so one bit-clock period is 2*(`sclk_div`+1) ticks. A tick presented in one cycle is counted at the next clock edge, and the level it completes appears one edge after that.
- R2: With `src_sel`=1 the divider counts `src_tick_b`; with `src_sel`=0 it counts `src_tick_a`.
- R3: While `sclk_en`=0, several things hold. `pcm_sclk`, `pcm_fsync` and `pcm_dout` stay low, `tx_pop` and `rx_push` stay low, and a later start begins again from R1.
- R4: While `tx_en`=0 and `rx_en`=0, the engine keeps running when `idle_run`=1. When `idle_run`=0 it stops as in R3.
- R5: The first falling edge of `pcm_sclk` after a start opens slot 0. Each further falling edge opens the next slot, and slot `frame_div` is followed by slot 0, so a frame is `frame_div`+1 bit periods long. `pcm_fsync` is high for exactly slot 0 and changes only together with a falling edge.
- R6: With `tx_late`=0, the left sample goes out MSB-first in slots 0 to 15 and the right sample in slots 16 to 31. `pcm_dout` changes on falling edges and is 0 in every other slot.
- R7: With `tx_late`=1, the transmit lanes move one slot later, to slots 1 to 16 and 17 to 32. This needs `frame_div` >= 32.
- R8: `tx_pop` is high for exactly one cycle, the cycle just before the falling edge that opens a lane's first slot. The block takes `tx_data` of that cycle as the lane's sample. There is exactly one pop per lane.
- R9: While `tx_en`=0 there is no pop. From the next falling edge onward, `pcm_dout` is 0.
- R10: `pcm_din` is sampled when `pcm_sclk` rises, and 16 samples form one channel, MSB first. `rx_push` is high for one cycle, the same cycle in which `pcm_sclk` goes high for the lane's 16th bit, and `rx_data` then holds the sample.
- R11: `rx_late` moves the receive lanes to slots 0-31 (`rx_late`=0) or 1-32 (`rx_late`=1), independently of `tx_late`.
- R12: A receive lane is pushed only if `rx_en` was high for all 16 of its rising edges. A lane that is entered part-way through is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick_a | input | 1 | Tick pulses of the first source clock |
| src_tick_b | input | 1 | Tick pulses of the second source clock |
| src_sel | input | 1 | 1 selects `src_tick_b`, 0 selects `src_tick_a` |
| sclk_div | input | DIV_W | Half-period of the bit clock minus one, in ticks |
| frame_div | input | DIV_W | Bit periods per frame minus one |
| sclk_en | input | 1 | Bit clock enable |
| idle_run | input | 1 | Keep the bit clock running with both directions off |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_late | input | 1 | Transmit MSB one slot after sync |
| rx_late | input | 1 | Receive MSB one slot after sync |
| tx_data | input | SAMPLE_W | Head of the transmit FIFO |
| tx_pop | output | 1 | Transmit FIFO pop strobe |
| rx_data | output | SAMPLE_W | Received sample |
| rx_push | output | 1 | Receive FIFO push strobe |
| pcm_sclk | output | 1 | Bit clock |
| pcm_fsync | output | 1 | Frame sync |
| pcm_dout | output | 1 | Serial transmit data |
| pcm_din | input | 1 | Serial receive data |

## Verification
In the sync-aligned format, one falling edge does three things at once: it raises the frame sync, pops the left sample and puts that sample's MSB on the pin. With the late format and a 33-slot frame, the last right-channel bit is shifted on the same falling edge that wraps the slot count to zero. Both coincidences are provoked with a divider of zero and a tick in every cycle, and a mixed run sets the two directions to different formats. A behavioural model in the bench tracks edges and slot numbers with integers and queues the expected receive words. It is compared with every output on every cycle, so a pop, a sync or a data bit that moves by one cycle is reported.

// File: rtl/pcm_tg_pkg.sv
package pcm_tg_pkg;

  // One-cycle events marking the bit clock edge about to be taken.
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_evt_t;

  // Slot that follows `pos` in a frame whose final slot is `last`.
  function automatic int slot_after(int pos, int last);
    return (pos >= last) ? 0 : pos + 1;
  endfunction

  // True when slot `pos` carries data for a lane block starting at `off`.
  function automatic bit lane_hit(int pos, int off, int w, int lanes);
    int rel;
    rel = pos - off;
    return (rel >= 0) && (rel < w * lanes);
  endfunction

  // First (MSB) slot of any lane.
  function automatic bit lane_first(int pos, int off, int w, int lanes);
    return lane_hit(pos, off, w, lanes) && (((pos - off) % w) == 0);
  endfunction

  // Last (LSB) slot of any lane.
  function automatic bit lane_last(int pos, int off, int w, int lanes);
    return lane_hit(pos, off, w, lanes) && (((pos - off) % w) == (w - 1));
  endfunction

endpackage

// File: rtl/pcm_bitclk_div.sv
module pcm_bitclk_div #(
  parameter int DIV_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_a,
  input  logic                  tick_b,
  input  logic                  sel,
  input  logic [DIV_W-1:0]      half_div,
  input  logic                  run,
  output logic                  sclk,
  output pcm_tg_pkg::sclk_evt_t evt
);
  localparam logic [DIV_W-1:0] CNT_STEP = DIV_W'(1);

  logic             tick_q;
  logic [DIV_W-1:0] hcnt;
  logic             lvl;
  logic             flip;

  // R2: pick the source and register its tick (one cycle of latency, R1).
  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= sel ? tick_b : tick_a;
  end

  // R1: a level ends after half_div+1 counted ticks; >= guards a shrunk divider.
  assign flip = run & tick_q & (hcnt >= half_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      lvl  <= 1'b0;
    end else if (!run) begin
      hcnt <= '0;
      lvl  <= 1'b0;
    end else if (tick_q) begin
      if (flip) begin
        hcnt <= '0;
        lvl  <= ~lvl;
      end else begin
        hcnt <= hcnt + CNT_STEP;
      end
    end
  end

  assign sclk     = lvl;
  assign evt.rise = flip & ~lvl;
  assign evt.fall = flip & lvl;
endmodule

// File: rtl/pcm_frame_pos.sv
module pcm_frame_pos #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fall,
  input  logic [POS_W-1:0] last,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_nxt,
  output logic             fsync
);
  logic [POS_W-1:0] pos_q;
  logic             fs_q;

  // R5: parked at all-ones, so the first falling edge always opens slot 0.
  assign pos_nxt = POS_W'(pcm_tg_pkg::slot_after(int'(pos_q), int'(last)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '1;
      fs_q  <= 1'b0;
    end else if (!run) begin
      pos_q <= '1;
      fs_q  <= 1'b0;
    end else if (fall) begin
      pos_q <= pos_nxt;
      fs_q  <= (pos_nxt == '0);
    end
  end

  assign pos   = pos_q;
  assign fsync = fs_q;
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 2,
  parameter int POS_W    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tx_en,
  input  logic                late,
  input  logic                fall,
  input  logic [POS_W-1:0]    pos_nxt,
  input  logic [SAMPLE_W-1:0] tx_data,
  output logic                tx_pop,
  output logic                dout
);
  localparam int LEFT_W = $clog2(SAMPLE_W);
  localparam logic [LEFT_W-1:0] LEFT_FULL = LEFT_W'(SAMPLE_W - 1);
  localparam logic [LEFT_W-1:0] LEFT_STEP = LEFT_W'(1);

  logic [SAMPLE_W-1:0] sr;
  logic [LEFT_W-1:0]   left;
  logic                dout_q;
  logic                lane_open;

  // R6/R7: a lane opens in the slot the coming falling edge enters.
  assign lane_open = tx_en &
    pcm_tg_pkg::lane_first(int'(pos_nxt), int'(late), SAMPLE_W, LANES);

  // R8/R9: pop in the cycle of that falling edge, only while enabled.
  assign tx_pop = fall & lane_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      left   <= '0;
      dout_q <= 1'b0;
    end else if (!run) begin
      sr     <= '0;
      left   <= '0;
      dout_q <= 1'b0;
    end else if (fall) begin
      if (lane_open) begin
        sr     <= tx_data;
        left   <= LEFT_FULL;
        dout_q <= tx_data[SAMPLE_W-1];
      end else if (tx_en && left != '0) begin
        sr     <= sr << 1;
        left   <= left - LEFT_STEP;
        dout_q <= sr[SAMPLE_W-2];
      end else begin
        left   <= '0;
        dout_q <= 1'b0;
      end
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 2,
  parameter int POS_W    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                rx_en,
  input  logic                late,
  input  logic                rise,
  input  logic [POS_W-1:0]    pos,
  input  logic                din,
  output logic                rx_push,
  output logic [SAMPLE_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-2:0] sr;
  logic [CNT_W-1:0]    got;
  logic                push_q;
  logic [SAMPLE_W-1:0] data_q;
  logic                in_win, is_first, is_last;

  // R11: slot window chosen per direction.
  assign in_win   = pcm_tg_pkg::lane_hit  (int'(pos), int'(late), SAMPLE_W, LANES);
  assign is_first = pcm_tg_pkg::lane_first(int'(pos), int'(late), SAMPLE_W, LANES);
  assign is_last  = pcm_tg_pkg::lane_last (int'(pos), int'(late), SAMPLE_W, LANES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      got    <= '0;
      push_q <= 1'b0;
      data_q <= '0;
    end else begin
      push_q <= 1'b0;
      if (!run) begin
        sr  <= '0;
        got <= '0;
      end else if (rise) begin
        if (!rx_en || !in_win) begin
          got <= '0;                         // R12: partial lanes restart
        end else begin
          sr <= {sr[SAMPLE_W-3:0], din};     // R10: MSB first
          if (is_first)        got <= CNT_ONE;
          else if (got != '0) got <= got + CNT_ONE;
          if (is_last && got == CNT_LAST) begin
            data_q <= {sr, din};
            push_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_push = push_q;
  assign rx_data = data_q;
endmodule

// File: rtl/pcm_master_port.sv
module pcm_master_port #(
  parameter int DIV_W    = 9,
  parameter int SAMPLE_W = 16,
  parameter int LANES    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_tick_a,
  input  logic                src_tick_b,
  input  logic                src_sel,
  input  logic [DIV_W-1:0]    sclk_div,
  input  logic [DIV_W-1:0]    frame_div,
  input  logic                sclk_en,
  input  logic                idle_run,
  input  logic                tx_en,
  input  logic                rx_en,
  input  logic                tx_late,
  input  logic                rx_late,
  input  logic [SAMPLE_W-1:0] tx_data,
  output logic                tx_pop,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_push,
  output logic                pcm_sclk,
  output logic                pcm_fsync,
  output logic                pcm_dout,
  input  logic                pcm_din
);
  localparam int POS_W = DIV_W;

  logic                  run_w;
  pcm_tg_pkg::sclk_evt_t evt_w;
  logic [POS_W-1:0]      pos_w, pos_nxt_w;

  // R3/R4: run only with the clock enabled and a direction or the idle policy on.
  assign run_w = sclk_en & (tx_en | rx_en | idle_run);

  pcm_bitclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_a(src_tick_a), .tick_b(src_tick_b),
    .sel(src_sel), .half_div(sclk_div), .run(run_w),
    .sclk(pcm_sclk), .evt(evt_w)
  );

  pcm_frame_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .run(run_w), .fall(evt_w.fall),
    .last(frame_div), .pos(pos_w), .pos_nxt(pos_nxt_w), .fsync(pcm_fsync)
  );

  pcm_tx_lane #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .POS_W(POS_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .run(run_w), .tx_en(tx_en), .late(tx_late),
    .fall(evt_w.fall), .pos_nxt(pos_nxt_w), .tx_data(tx_data),
    .tx_pop(tx_pop), .dout(pcm_dout)
  );

  pcm_rx_lane #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .POS_W(POS_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .run(run_w), .rx_en(rx_en), .late(rx_late),
    .rise(evt_w.rise), .pos(pos_w), .din(pcm_din),
    .rx_push(rx_push), .rx_data(rx_data)
  );
endmodule

// File: rtl/pcm_master_port_chk.sv
module pcm_master_port_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic tx_en,
  input logic tx_pop,
  input logic rx_push,
  input logic pcm_sclk,
  input logic pcm_fsync
);
  // R3: a stopped engine leaves the bit clock low.
  a_r3_sclk_low_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !pcm_sclk);

  // R5: while running, sync changes only together with a falling edge.
  a_r5_fsync_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(pcm_fsync)) |-> $fell(pcm_sclk));

  // R5: sync opens while the bit clock is low.
  a_r5_fsync_rises_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_fsync) |-> !pcm_sclk);

  // R8: a pop is followed at once by a falling edge.
  a_r8_pop_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> $fell(pcm_sclk));

  // R9: no pop while transmit is off.
  a_r9_no_pop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_pop);

  // R10: a push appears with the rising edge that completed it.
  a_r10_push_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $rose(pcm_sclk));
endmodule

bind pcm_master_port pcm_master_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_w), .tx_en(tx_en), .tx_pop(tx_pop),
  .rx_push(rx_push), .pcm_sclk(pcm_sclk), .pcm_fsync(pcm_fsync)
);

// File: tb/pcm_master_port_bench.sv
module pcm_master_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_tick_a = 1'b0, src_tick_b = 1'b1, src_sel = 1'b1;
  logic [8:0]  sclk_div = 9'd0, frame_div = 9'd32;
  logic        sclk_en = 1'b0, idle_run = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic        tx_late = 1'b0, rx_late = 1'b0;
  logic [15:0] tx_data;
  logic        tx_pop, rx_push, pcm_sclk, pcm_fsync, pcm_dout;
  logic        pcm_din = 1'b0;
  logic [15:0] rx_data;

  pcm_master_port u_pcm_master_port (
    .clk(clk), .rst_n(rst_n), .src_tick_a(src_tick_a), .src_tick_b(src_tick_b),
    .src_sel(src_sel), .sclk_div(sclk_div), .frame_div(frame_div),
    .sclk_en(sclk_en), .idle_run(idle_run), .tx_en(tx_en), .rx_en(rx_en),
    .tx_late(tx_late), .rx_late(rx_late), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_push(rx_push), .pcm_sclk(pcm_sclk),
    .pcm_fsync(pcm_fsync), .pcm_dout(pcm_dout), .pcm_din(pcm_din)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string t_clk = "R1", t_tx = "R6", t_rx = "R10";

  function automatic logic [15:0] sample(int k);
    return 16'((k * 40503 + 12345) & 16'hFFFF);
  endfunction

  // ---------------- reference model (edge and slot counts as integers)
  int          m_tcnt, m_edges, m_txleft, m_pc, m_rxbits;
  bit          m_tickd, m_sclk, m_fs, m_dout, m_push;
  logic [15:0] m_txword, m_rxword;
  logic [15:0] rxq[$];
  bit          pop_seen = 1'b0;
  int          dpc = 0;

  function automatic bit running();
    return sclk_en && (tx_en || rx_en || idle_run);
  endfunction

  task automatic rx_step(int pos);
    int rel;
    rel = pos - int'(rx_late);
    if (!rx_en || rel < 0 || rel >= 32) m_rxbits = 0;
    else begin
      m_rxword = {m_rxword[14:0], pcm_din};
      if (rel % 16 == 0) m_rxbits = 1;
      else if (m_rxbits > 0) m_rxbits++;
      if (rel % 16 == 15 && m_rxbits == 16) begin
        m_push = 1'b1;
        rxq.push_back(m_rxword);
      end
    end
  endtask

  task automatic tx_step(int pos);
    int rel;
    rel = pos - int'(tx_late);
    if (tx_en && rel >= 0 && rel < 32 && rel % 16 == 0) begin
      m_txword = sample(m_pc); m_pc++; m_txleft = 15; m_dout = m_txword[15];
    end else if (tx_en && m_txleft > 0) begin
      m_txword = m_txword << 1; m_txleft--; m_dout = m_txword[15];
    end else begin
      m_txleft = 0; m_dout = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tickd = 0; m_tcnt = 0; m_edges = 0; m_sclk = 0; m_fs = 0; m_dout = 0;
      m_push = 0; m_txleft = 0; m_rxbits = 0; m_pc = 0;
    end else begin
      m_push = 1'b0;
      if (!running()) begin
        m_tcnt = 0; m_edges = 0; m_sclk = 0; m_fs = 0; m_dout = 0;
        m_txleft = 0; m_rxbits = 0;
      end else if (m_tickd) begin
        m_tcnt++;
        if (m_tcnt == int'(sclk_div) + 1) begin
          m_tcnt = 0; m_edges++;
          if (m_edges % 2 == 1) begin
            m_sclk = 1'b1;
            if (m_edges >= 3) rx_step(((m_edges - 3) / 2) % (int'(frame_div) + 1));
            else m_rxbits = 0;
          end else begin
            m_sclk = 1'b0;
            m_fs = (((m_edges / 2 - 1) % (int'(frame_div) + 1)) == 0);
            tx_step((m_edges / 2 - 1) % (int'(frame_div) + 1));
          end
        end
      end
      m_tickd = src_sel ? src_tick_b : src_tick_a;
    end
  end

  function automatic bit pop_expected();
    int np, rel;
    if (!running() || !m_tickd || m_tcnt + 1 != int'(sclk_div) + 1) return 1'b0;
    if (m_edges % 2 == 0 || !tx_en) return 1'b0;
    np  = ((m_edges + 1) / 2 - 1) % (int'(frame_div) + 1);
    rel = np - int'(tx_late);
    return rel >= 0 && rel < 32 && rel % 16 == 0;
  endfunction

  task automatic chk(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk16(logic [15:0] act, logic [15:0] exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] exp_w;
      chk(pcm_sclk,  m_sclk, t_clk, "pcm_sclk");
      chk(pcm_fsync, m_fs,   "R5",  "pcm_fsync");
      chk(pcm_dout,  m_dout, t_tx,  "pcm_dout");
      chk(tx_pop, pop_expected(), "R8", "tx_pop");
      chk(rx_push, m_push, t_rx, "rx_push");
      if (rx_push || m_push) begin
        if (rxq.size() == 0) begin
          chk(1'b1, 1'b0, t_rx, "rx_push with no sample due");
        end else begin
          exp_w = rxq.pop_front();
          if (rx_push) chk16(rx_data, exp_w, t_rx, "rx_data");
        end
      end
      pop_seen = tx_pop;
    end
  end

  // ---------------- stimulus drivers (inputs move 1 ns after the edge)
  always @(posedge clk) begin
    #1;
    src_tick_a = 1'($urandom % 2);
    pcm_din    = 1'($urandom % 2);
    if (pop_seen) dpc++;
    pop_seen = 1'b0;
    tx_data  = sample(dpc);
  end

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic stop_engine();
    wait_cycles(1);
    sclk_en = 1'b0;
    wait_cycles(4);
  endtask

  initial begin
    tx_data = sample(0);
    wait_cycles(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R3: reset state, everything quiet
    chk(pcm_sclk,  1'b0, "R1", "reset pcm_sclk");
    chk(pcm_fsync, 1'b0, "R3", "reset pcm_fsync");
    chk(pcm_dout,  1'b0, "R3", "reset pcm_dout");
    chk(tx_pop | rx_push, 1'b0, "R3", "reset strobes");

    // R1/R6/R10: sync-aligned both ways, fastest divider, 33-slot frame
    wait_cycles(1);
    t_clk = "R1"; t_tx = "R6"; t_rx = "R10";
    src_sel = 1'b1; sclk_div = 9'd0; frame_div = 9'd32;
    tx_en = 1'b1; rx_en = 1'b1; tx_late = 1'b0; rx_late = 1'b0; sclk_en = 1'b1;
    wait_cycles(800);
    stop_engine();

    // R7/R11/R5: late format both ways, last bit meets the frame wrap
    t_tx = "R7"; t_rx = "R11";
    tx_late = 1'b1; rx_late = 1'b1; sclk_en = 1'b1;
    wait_cycles(800);
    stop_engine();

    // R2/R7/R11: random source A, divider 2, 64-slot frame, mixed formats
    t_clk = "R2";
    src_sel = 1'b0; sclk_div = 9'd2; frame_div = 9'd63;
    tx_late = 1'b1; rx_late = 1'b0; sclk_en = 1'b1;
    wait_cycles(3000);
    stop_engine();

    // R9: transmit off, receive on
    t_clk = "R1"; t_tx = "R9"; t_rx = "R10";
    src_sel = 1'b1; sclk_div = 9'd1; frame_div = 9'd40;
    tx_en = 1'b0; rx_en = 1'b1; tx_late = 1'b0; sclk_en = 1'b1;
    wait_cycles(1000);
    stop_engine();

    // R12: receive enabled part-way through a lane
    t_tx = "R6"; t_rx = "R12";
    sclk_div = 9'd0; frame_div = 9'd32; idle_run = 1'b1;
    tx_en = 1'b1; rx_en = 1'b0; sclk_en = 1'b1;
    wait_cycles(37);
    rx_en = 1'b1;
    wait_cycles(600);
    rx_en = 1'b0;
    wait_cycles(21);
    rx_en = 1'b1;
    wait_cycles(600);
    stop_engine();

    // R4: idle policy with both directions off
    t_clk = "R4"; t_tx = "R4"; t_rx = "R4";
    tx_en = 1'b0; rx_en = 1'b0; idle_run = 1'b1; sclk_en = 1'b1;
    wait_cycles(400);
    idle_run = 1'b0;
    wait_cycles(200);

    // R3: clock enable off while transmit wants to run
    t_clk = "R3"; t_tx = "R3"; t_rx = "R3";
    tx_en = 1'b1; rx_en = 1'b1; sclk_en = 1'b0;
    wait_cycles(300);
    @(negedge clk);
    chk(pcm_sclk, 1'b0, "R3", "held pcm_sclk");
    chk(pcm_fsync, 1'b0, "R3", "held pcm_fsync");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule